// File: doc/BRIEF.md
# AHB-to-APB Lane-Replicating Bridge

This block sits between an AHB-Lite system bus and a 32-bit APB peripheral bus that shares the system clock. It accepts one AHB transfer at a time. It runs that transfer on the APB side as a setup phase followed by an access phase, and it holds the AHB ready output low until the peripheral completes. Every access the peripheral sees is a full word. For byte and halfword writes, the narrow data is copied into every lane of the write vector, so the peripheral needs no byte strobes.

The APB side can run at the full system rate or at a slower rate. The slower rate uses a clock-enable strobe from the same clock domain. With the strobe tied high, the bridge runs at full rate. With the strobe toggling every cycle, it runs at half rate. An error flagged by the peripheral comes back to the AHB master as the standard two-cycle error response. Read data is returned as the full word.

Top module: `ahb_apb_lane_bridge`

## Requirements
- R1: After synchronous reset, `psel` and `penable` are 0, `hreadyout` is 1 and `hresp` is 0.
- R2: A transfer is accepted only when `hsel`=1, `hready_in`=1 and `htrans` is 2'b10 or 2'b11. Any other combination causes no APB activity and leaves `hreadyout` at 1.
- R3: Every APB transfer first spends one peripheral cycle with `psel`=1 and `penable`=0. It then keeps `penable`=1 together with `psel`=1 until a peripheral cycle in which `pready` is 1.
- R4: With `pclk_en` held at 1, `hreadyout` stays low for exactly 3+W cycles after the address phase. W is the number of access-phase cycles in which `pready` is 0.
- R5: A write with `hsize`=0 takes the byte on lane `haddr[1:0]` of `hwdata` and drives it on all four byte lanes of `pwdata`.
- R6: A write with `hsize`=1 takes the halfword on lane `haddr[1]` of `hwdata` and drives it on both halfword lanes of `pwdata`.
- R7: A write with `hsize`=2 drives `hwdata` onto `pwdata` unchanged.
- R8: `paddr` equals the transfer address with bits [1:0] cleared, and `pwrite` equals `hwrite`.
- R9: The `prdata` value sampled at completion appears on `hrdata` in the cycle in which `hreadyout` returns to 1.
- R10: If `pslverr` is 1 at completion, `hresp` is 1 for two cycles: first with `hreadyout`=0, then with `hreadyout`=1. The next transfer then completes with `hresp`=0.
- R11: `psel` and `penable` change only on clock edges at which `pclk_en` is 1. With `pclk_en` toggling every cycle and no wait states, `hreadyout` stays low for 5 or 6 cycles.
- R12: In the cycle in which `hreadyout` returns to 1 after a successful transfer, `psel` and `penable` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_en | input | 1 | Peripheral clock-enable strobe (tie high for full rate) |
| hsel | input | 1 | AHB slave select |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write flag |
| hsize | input | 3 | AHB transfer size |
| hwdata | input | DATA_W | AHB write data (data phase) |
| hready_in | input | 1 | AHB bus ready seen by all slaves |
| hreadyout | output | 1 | Bridge ready toward AHB |
| hresp | output | 1 | Bridge error response |
| hrdata | output | DATA_W | Read data toward AHB |
| paddr | output | ADDR_W | APB address, word aligned |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write flag |
| pwdata | output | DATA_W | APB write data, lanes replicated |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB error |

## Verification
If the sequencer gets stuck in or skips a state, the AHB stall length changes on the first transfer. The stall is expected to be 3+W cycles at full rate and 5 or 6 cycles at half rate, so the bench sees the error at the first `hreadyout` rising edge. A wrong captured size or lane index shows up in `pwdata` as soon as that write completes, because off-lane bytes carry distinct filler values. If the enable strobe is ignored, `psel` or `penable` toggles on a disabled edge; the bench sees that within one cycle, and the error path shows the same failure through the two-cycle `hresp` pattern.

// File: rtl/apbbr_pkg.sv
package apbbr_pkg;
  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SETUP,
    ST_ACCESS,
    ST_ERR1,
    ST_ERR2
  } br_state_t;
endpackage

// File: rtl/apbbr_lanes.sv
module apbbr_lanes #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        size,
  input  logic [LB-1:0]     lsb,
  output logic [DATA_W-1:0] rep
);
  import apbbr_pkg::*;

  logic [7:0]        byte_v;
  logic [15:0]       half_v;
  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  // pick the narrow datum from the lane its address selects
  always_comb begin
    byte_v = wdata[{lsb, 3'b000} +: 8];
    half_v = wdata[{lsb[LB-1:1], 4'b0000} +: 16];
  end

  // copy it into every lane of the word
  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign byte_rep[g*8 +: 8] = byte_v;
  end
  for (genvar g = 0; g < LANES / 2; g++) begin : g_half
    assign half_rep[g*16 +: 16] = half_v;
  end

  always_comb begin
    if (size == SZ_BYTE)      rep = byte_rep;
    else if (size == SZ_HALF) rep = half_rep;
    else                      rep = wdata;
  end
endmodule

// File: rtl/apbbr_seq.sv
module apbbr_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_en,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic              hready_in,
  input  logic [DATA_W-1:0] rep_wdata,
  output logic [2:0]        cap_size,
  output logic [LB-1:0]     cap_lsb,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  import apbbr_pkg::*;

  br_state_t state;
  logic      valid_tr;
  logic      accept;

  assign valid_tr = hsel && hready_in && ((htrans == 2'b10) || (htrans == 2'b11));
  assign accept   = valid_tr && ((state == ST_IDLE) || (state == ST_ERR2));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hreadyout <= 1'b1;
      hresp     <= 1'b0;
      hrdata    <= '0;
      paddr     <= '0;
      psel      <= 1'b0;
      penable   <= 1'b0;
      pwrite    <= 1'b0;
      pwdata    <= '0;
      cap_size  <= '0;
      cap_lsb   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_ERR2: begin
          hresp     <= 1'b0;
          hreadyout <= 1'b1;
          state     <= ST_IDLE;
          if (accept) begin
            paddr     <= {haddr[ADDR_W-1:LB], {LB{1'b0}}};
            pwrite    <= hwrite;
            cap_size  <= hsize;
            cap_lsb   <= haddr[LB-1:0];
            hreadyout <= 1'b0;
            state     <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (pclk_en) begin
            psel   <= 1'b1;
            pwdata <= rep_wdata;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (pclk_en) begin
            penable <= 1'b1;
            state   <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (pclk_en && pready) begin
            psel    <= 1'b0;
            penable <= 1'b0;
            hrdata  <= prdata;
            if (pslverr) begin
              hresp <= 1'b1;
              state <= ST_ERR1;
            end else begin
              hreadyout <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_ERR1: begin
          hreadyout <= 1'b1;
          state     <= ST_ERR2;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: setup phase always precedes access phase
  p_setup_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(penable) |-> ($past(psel) && !$past(penable)));
  // R3: enable only with select
  p_enable_in_sel_r3: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);
  // R3: access phase held until the peripheral is ready on an enabled edge
  p_hold_access_r3: assert property (@(posedge clk) disable iff (rst)
    (penable && !(pclk_en && pready)) |=> penable);
  // R4: AHB is stalled while the peripheral is selected
  p_stall_while_sel_r4: assert property (@(posedge clk) disable iff (rst)
    psel |-> !hreadyout);
  // R10: error response is a two-cycle pair
  p_err_pair_r10: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hreadyout) |=> (hresp && hreadyout));
  // R11: APB phases move only on enabled edges
  p_gated_phase_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(pclk_en) && !$past(rst)) |-> ($stable(psel) && $stable(penable)));
endmodule

// File: rtl/ahb_apb_lane_bridge.sv
module ahb_apb_lane_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_en,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready_in,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  logic [DATA_W-1:0] rep_wdata;
  logic [2:0]        cap_size;
  logic [LB-1:0]     cap_lsb;

  apbbr_lanes #(.DATA_W(DATA_W)) u_lanes (
    .wdata (hwdata),
    .size  (cap_size),
    .lsb   (cap_lsb),
    .rep   (rep_wdata)
  );

  apbbr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pclk_en   (pclk_en),
    .hsel      (hsel),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hready_in (hready_in),
    .rep_wdata (rep_wdata),
    .cap_size  (cap_size),
    .cap_lsb   (cap_lsb),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .hrdata    (hrdata),
    .paddr     (paddr),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr)
  );
endmodule

// File: tb/ahb_apb_lane_bridge_tb.sv
`timescale 1ns/1ps
module ahb_apb_lane_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pclk_en = 1'b1;
  logic        hsel = 1'b0;
  logic [15:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [31:0] hwdata = '0;
  logic        hready_in;
  logic        hreadyout, hresp, psel, penable, pwrite;
  logic [31:0] hrdata, pwdata;
  logic [15:0] paddr;
  logic [31:0] prdata = '0;
  logic        pready = 1'b0;
  logic        pslverr = 1'b0;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;
  bit   half = 0;
  int   slv_waits = 0;
  bit   slv_err = 0;
  int   slv_cnt = 0;
  logic [31:0] last_wdata = '0;
  logic [15:0] last_paddr = '0;
  logic        last_pwrite = 1'b0;
  logic        en_prev = 1'b1;
  logic        psel_q = 1'b0, penable_q = 1'b0;
  int          gate_viol = 0;
  int          setup_viol = 0;

  always #10 clk = ~clk;
  assign hready_in = hreadyout;

  ahb_apb_lane_bridge #(.ADDR_W(16), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .pclk_en(pclk_en), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
    .hready_in(hready_in), .hreadyout(hreadyout), .hresp(hresp),
    .hrdata(hrdata), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  // peripheral clock-enable strobe
  always @(negedge clk) pclk_en <= half ? ~pclk_en : 1'b1;

  // peripheral model with programmable wait states and error
  always @(negedge clk) begin
    if (psel && penable) begin
      if (slv_cnt >= slv_waits) begin
        pready  = 1'b1;
        pslverr = slv_err;
        prdata  = 32'hC0DE0000 | {16'h0, paddr};
      end else begin
        pready = 1'b0;
        slv_cnt++;
      end
    end else begin
      pready  = 1'b0;
      pslverr = 1'b0;
      slv_cnt = 0;
    end
  end

  always @(posedge clk) begin
    en_prev <= pclk_en;
    if (psel && penable && pready && pclk_en) begin
      last_wdata  <= pwdata;
      last_paddr  <= paddr;
      last_pwrite <= pwrite;
    end
  end

  // protocol monitors (R3, R11)
  always @(negedge clk) begin
    if (!rst) begin
      if (((psel != psel_q) || (penable != penable_q)) && !en_prev) gate_viol++;
      if (penable && !penable_q && !(psel_q && !penable_q)) setup_viol++;
    end
    psel_q    = psel;
    penable_q = penable;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one AHB transfer; starts and ends on a falling edge
  task automatic xfer(input logic wr, input logic [15:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic rsp, output int stalls, output logic err_low);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    stalls = 0; err_low = 1'b0;
    while (!hreadyout && stalls < 100) begin
      stalls++;
      err_low = hresp;
      @(negedge clk);
    end
    if (stalls >= 100) check(1'b0, "watchdog", 32'(stalls), 32'd0);
    rd = hrdata;
    rsp = hresp;
  endtask

  task automatic t_reset();
    check(psel == 1'b0 && penable == 1'b0, "R1 select/enable", {psel, penable}, 0);
    check(hreadyout == 1'b1 && hresp == 1'b0, "R1 ready/resp", {hreadyout, hresp}, 2);
  endtask

  task automatic t_word_write();
    logic [31:0] rd; logic rsp, el; int st;
    xfer(1'b1, 16'h0107, 3'd2, 32'h89ABCDEF, rd, rsp, st, el);
    check(st == 3, "R4 stall no waits", st, 3);
    check(psel == 1'b0 && penable == 1'b0, "R12 idle at completion", {psel, penable}, 0);
    check(last_wdata == 32'h89ABCDEF, "R7 word data", last_wdata, 32'h89ABCDEF);
    check(last_paddr == 16'h0104, "R8 aligned address", last_paddr, 16'h0104);
    check(last_pwrite == 1'b1 && rsp == 1'b0, "R8 write flag", {last_pwrite, rsp}, 2);
  endtask

  task automatic t_byte_writes();
    logic [31:0] rd; logic rsp, el; int st;
    xfer(1'b1, 16'h0012, 3'd0, 32'h11A52233, rd, rsp, st, el);
    check(last_wdata == 32'hA5A5A5A5, "R5 byte lane2", last_wdata, 32'hA5A5A5A5);
    xfer(1'b1, 16'h0011, 3'd0, 32'h11A52233, rd, rsp, st, el);
    check(last_wdata == 32'h22222222, "R5 byte lane1", last_wdata, 32'h22222222);
    xfer(1'b1, 16'h0013, 3'd0, 32'h7F000000, rd, rsp, st, el);
    check(last_wdata == 32'h7F7F7F7F, "R5 byte lane3", last_wdata, 32'h7F7F7F7F);
  endtask

  task automatic t_half_writes();
    logic [31:0] rd; logic rsp, el; int st;
    xfer(1'b1, 16'h0022, 3'd1, 32'hBEEF1234, rd, rsp, st, el);
    check(last_wdata == 32'hBEEFBEEF, "R6 upper half", last_wdata, 32'hBEEFBEEF);
    xfer(1'b1, 16'h0020, 3'd1, 32'hBEEF1234, rd, rsp, st, el);
    check(last_wdata == 32'h12341234, "R6 lower half", last_wdata, 32'h12341234);
  endtask

  task automatic t_read();
    logic [31:0] rd; logic rsp, el; int st;
    xfer(1'b0, 16'h0A5E, 3'd2, 32'h0, rd, rsp, st, el);
    check(rd == 32'hC0DE0A5C, "R9 read data", rd, 32'hC0DE0A5C);
    check(last_pwrite == 1'b0, "R8 read flag", last_pwrite, 0);
  endtask

  task automatic t_waits();
    logic [31:0] rd; logic rsp, el; int st;
    slv_waits = 2;
    xfer(1'b1, 16'h0040, 3'd2, 32'h00C0FFEE, rd, rsp, st, el);
    check(st == 5, "R4 stall two waits", st, 5);
    slv_waits = 5;
    xfer(1'b0, 16'h0044, 3'd2, 32'h0, rd, rsp, st, el);
    check(st == 8, "R4 stall five waits", st, 8);
    check(rd == 32'hC0DE0044, "R9 read after waits", rd, 32'hC0DE0044);
    slv_waits = 0;
  endtask

  task automatic t_error();
    logic [31:0] rd; logic rsp, el; int st;
    slv_err = 1;
    xfer(1'b1, 16'h0080, 3'd2, 32'h1, rd, rsp, st, el);
    check(rsp == 1'b1 && el == 1'b1, "R10 two-cycle error", {rsp, el}, 3);
    check(st == 4, "R10 error stall", st, 4);
    slv_err = 0;
    xfer(1'b0, 16'h0084, 3'd2, 32'h0, rd, rsp, st, el);
    check(rsp == 1'b0 && rd == 32'hC0DE0084, "R10 recovery", {31'h0, rsp}, 0);
  endtask

  task automatic t_ignore();
    int sel_seen = 0, rdy_low = 0;
    hsel = 1'b1; htrans = 2'b00; haddr = 16'h0100; hwrite = 1'b1;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b10;
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b01;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    for (int i = 0; i < 4; i++) begin
      if (psel) sel_seen++;
      if (!hreadyout) rdy_low++;
      @(negedge clk);
    end
    check(sel_seen == 0, "R2 no APB activity", sel_seen, 0);
    check(rdy_low == 0, "R2 ready stays high", rdy_low, 0);
  endtask

  task automatic t_half_rate();
    logic [31:0] rd; logic rsp, el; int st;
    int gv0;
    gv0 = gate_viol;
    half = 1;
    @(negedge clk);
    @(negedge clk);
    xfer(1'b1, 16'h0200, 3'd0, 32'h0000005A, rd, rsp, st, el);
    check(st >= 5 && st <= 6, "R11 half-rate stall", st, 5);
    check(last_wdata == 32'h5A5A5A5A, "R11 half-rate data", last_wdata, 32'h5A5A5A5A);
    @(negedge clk);
    xfer(1'b0, 16'h0206, 3'd2, 32'h0, rd, rsp, st, el);
    check(st >= 5 && st <= 6, "R11 half-rate read stall", st, 5);
    check(rd == 32'hC0DE0204, "R9 half-rate read", rd, 32'hC0DE0204);
    check(gate_viol == gv0, "R11 gated phase changes", gate_viol - gv0, 0);
    half = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_word_write();
    t_byte_writes();
    t_half_writes();
    t_read();
    t_waits();
    t_error();
    t_ignore();
    t_half_rate();
    check(setup_viol == 0, "R3 setup before access", setup_viol, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule